// File: doc/BRIEF.md
# Low-Order Interleaved Bank Controller

This block sits between a single word-wide request port and a set of independent memory banks. Each request carries a word address. The lowest address bits pick a bank inside a superbank, and the highest address bits pick the superbank. The bits in between give the row inside the bank. Consecutive words therefore land in consecutive banks. Two streams in different superbanks never contend for the same bank.

Every bank owns a small storage array, a one-word data buffer and a busy counter that models a fixed cycle time. A request is accepted as soon as its target bank is idle, whatever the other banks are doing. Writes to different banks therefore overlap freely. A line-fill request starts a read in every bank of one superbank on the same clock edge. The fetched words are then handed out one per cycle over the single-word response path.

A tag queue records which bank owns each outstanding read word. Responses therefore leave in the order the requests were accepted, even when a later bank's data is ready first. A bank that holds an unclaimed read word stays busy until that word has left the response port.

Top module: `ilv_bank_ctrl`

## Requirements
- R1: The address maps as follows: bank = addr[log2(NBANK)-1:0], superbank = the top log2(NSUPER) address bits, row = the bits in between. Two requests that differ in bank or superbank are accepted on consecutive edges. Two single requests to the same bank and superbank are held apart.
- R2: Single requests to distinct idle banks are accepted on every clock edge, writes included. A sweep of writes over consecutive addresses completes at one word per cycle when CYC <= NBANK.
- R3: After a write is accepted by a bank, the next request to that bank is accepted exactly CYC edges later. A bank holding a read word stays busy until that word has been delivered.
- R4: When the response queue is otherwise empty, a single read accepted on edge A presents rsp_valid with its data in the cycle after edge A+CYC-1.
- R5: Read words leave on rsp_data in acceptance order, at most one per cycle. rsp_valid is never raised without an outstanding read.
- R6: A request with req_line=1 and req_write=0 reads the NBANK words of the line containing req_addr. The low bank bits of req_addr are ignored. The line's words are returned for banks 0 to NBANK-1 in order, on NBANK consecutive cycles, starting CYC-1 edges after acceptance.
- R7: A line fill is accepted only when every bank of its superbank is idle and NBANK queue slots are free.
- R8: Superbanks are independent. A request to a second superbank is accepted on the edge right after a line fill in the first. Its word follows the line's words in order.
- R9: After reset, rsp_valid is 0 and req_ready is 1 for any single request.
- R10: A read returns the data of the most recent write to the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write one word, 0 = read |
| req_line | input | 1 | With req_write=0: read the whole line across all banks |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request accepted on this edge when req_valid is 1 |
| rsp_valid | output | 1 | A read word is on rsp_data |
| rsp_data | output | DW | Read data, in request order |

## Verification
The bench sweeps every address of a 64-word, 4-bank, 2-superbank configuration with writes, single reads and line fills, and checks each returned word against an arithmetic pattern. It measures acceptance edges to catch a bank chosen from the wrong address bits, which would serialise consecutive words or let a busy bank accept early. It also catches a counter off by one, which would stretch or shorten the CYC spacing. Further scenarios pit a line fill against a pending single read in the same superbank and against a request to the other superbank. A design that ignored the pending word would overwrite a bank's buffer. A design that returned data by completion instead of by tag would deliver the second superbank's word out of order. Unaligned line addresses check that the low bits really are ignored; a design that honoured them would return a shifted line.

// File: rtl/ilv_bank_ctrl.sv
module ilv_bank_ctrl #(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int NBANK  = 4,
  parameter int NSUPER = 2,
  parameter int CYC    = 3,
  parameter int QD     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_line,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  localparam int BB  = $clog2(NBANK);
  localparam int SB  = $clog2(NSUPER);
  localparam int SBW = (SB > 0) ? SB : 1;
  localparam int NT  = NBANK * NSUPER;
  localparam int TW  = $clog2(NT);
  localparam int RW  = AW - BB - SB;
  localparam int RD  = 1 << RW;
  localparam int QW  = $clog2(QD);
  localparam int CW  = (CYC > 1) ? $clog2(CYC) : 1;

  logic [BB-1:0]  bk;
  logic [SBW-1:0] sb;
  logic [RW-1:0]  row;
  logic [TW-1:0]  gid;
  logic           line_mode, line_ok, acc, pop;

  assign bk  = req_addr[BB-1:0];
  assign row = req_addr[BB +: RW];

  generate
    if (SB > 0) begin : g_sb
      assign sb = req_addr[AW-1 -: SB];
    end else begin : g_nosb
      assign sb = '0;
    end
  endgenerate

  assign gid       = TW'(int'(sb) * NBANK + int'(bk));
  assign line_mode = req_line && !req_write;

  logic [CW-1:0] cnt [NT];
  logic [NT-1:0] pend, idle, sel;
  logic [DW-1:0] dbuf [NT];
  logic [DW-1:0] mem  [NT][RD];

  always_comb begin
    for (int g = 0; g < NT; g++) begin
      idle[g] = (cnt[g] == '0) && !pend[g];
      sel[g]  = acc && (line_mode ? (int'(sb) == g / NBANK) : (int'(gid) == g));
    end
  end

  always_comb begin
    line_ok = 1'b1;
    for (int k = 0; k < NBANK; k++)
      if (!idle[TW'(int'(sb) * NBANK + k)]) line_ok = 1'b0;
  end

  logic [TW-1:0] tq [QD];
  logic [QW:0]   wp, rp, used;
  logic [TW-1:0] head;
  int            free_slots;

  assign used       = wp - rp;
  assign free_slots = QD - int'(used);
  assign head       = tq[rp[QW-1:0]];

  assign req_ready = line_mode ? (line_ok && free_slots >= NBANK)
                               : (idle[gid] && (req_write || free_slots >= 1));
  assign acc       = req_valid && req_ready;
  assign rsp_valid = (wp != rp) && pend[head] && (cnt[head] == '0);
  assign rsp_data  = dbuf[head];
  assign pop       = rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NT; g++) cnt[g] <= '0;
      pend <= '0;
    end else begin
      for (int g = 0; g < NT; g++) begin
        if (sel[g]) begin
          cnt[g]  <= CW'(CYC - 1);
          pend[g] <= !req_write;
        end else begin
          if (cnt[g] != '0) cnt[g] <= cnt[g] - 1'b1;
          if (pop && int'(head) == g) pend[g] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < NT; g++) begin
      if (sel[g]) begin
        if (req_write) mem[g][row] <= req_wdata;
        else           dbuf[g]     <= mem[g][row];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (acc && line_mode)      wp <= wp + (QW+1)'(NBANK);
      else if (acc && !req_write) wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (acc && line_mode) begin
      for (int k = 0; k < NBANK; k++)
        tq[QW'(int'(wp[QW-1:0]) + k)] <= TW'(int'(sb) * NBANK + k);
    end else if (acc && !req_write) begin
      tq[wp[QW-1:0]] <= gid;
    end
  end
endmodule

// File: rtl/ilv_bank_ctrl_chk.sv
module ilv_bank_ctrl_chk #(
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int NBANK  = 4,
  parameter int NSUPER = 2,
  parameter int CYC    = 3,
  parameter int QD     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          req_line,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data
);
  localparam int BB = $clog2(NBANK);
  localparam int SB = $clog2(NSUPER);

  logic acc, lm;
  int   outst;
  int   cb;

  assign acc = req_valid && req_ready;
  assign lm  = req_line && !req_write;
  assign cb  = int'(req_addr[BB-1:0]) + ((SB > 0) ? NBANK * int'(req_addr >> (AW - SB)) : 0);

  always_ff @(posedge clk) begin
    if (!rst_n) outst <= 0;
    else outst <= outst + ((acc && !req_write) ? (lm ? NBANK : 1) : 0) - (rsp_valid ? 1 : 0);
  end

  // R5
  rsp_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> outst > 0);

  // R7
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= QD);

  // R3
  bank_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CYC > 1 && acc && !lm) |=> !(acc && !lm && cb == $past(cb)));

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rsp_valid);

  // R5
  rsp_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$isunknown(rsp_data));
endmodule

bind ilv_bank_ctrl ilv_bank_ctrl_chk #(
  .AW(AW), .DW(DW), .NBANK(NBANK), .NSUPER(NSUPER), .CYC(CYC), .QD(QD)
) chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_line(req_line), .req_addr(req_addr), .req_wdata(req_wdata),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
);

// File: tb/ilv_bank_ctrl_test.sv
module ilv_bank_ctrl_test;
  localparam int PERIOD = 10;
  localparam int AW = 6, DW = 16, NBANK = 4, NSUPER = 2, CYC = 3, QD = 8;
  localparam int NW = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_line = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_data;

  ilv_bank_ctrl #(.AW(AW), .DW(DW), .NBANK(NBANK), .NSUPER(NSUPER), .CYC(CYC), .QD(QD)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_line(req_line), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  always #(PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [DW-1:0] model [NW];
  logic [DW-1:0] exp_q [4096];
  int ew = 0, er = 0, rsp_cnt = 0, last_rsp = 0, acc_at = 0;

  function automatic logic [DW-1:0] pat(int a);
    return DW'(a * 37 + 5);
  endfunction

  task automatic check(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (er == ew) check("R5 unexpected response", 1, 0);
      else begin
        check("R5/R10 response data", int'(rsp_data), int'(exp_q[er]));
        er++;
      end
      rsp_cnt++;
      last_rsp = cyc;
    end
  end

  task automatic issue(bit w, bit ln, int a, logic [DW-1:0] d);
    req_valid = 1; req_write = w; req_line = ln;
    req_addr = AW'(a); req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    acc_at = cyc + 1;
    if (w) model[a] = d;
    else if (ln) begin
      for (int k = 0; k < NBANK; k++) begin
        exp_q[ew] = model[(a / NBANK) * NBANK + k]; ew++;
      end
    end else begin
      exp_q[ew] = model[a]; ew++;
    end
    @(negedge clk);
    req_valid = 0; req_line = 0;
  endtask

  task automatic drain();
    while (er != ew) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  int a0, a1, a2, n0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R9 rsp_valid after reset", int'(rsp_valid), 0);
    check("R9 req_ready after reset", int'(req_ready), 1);
    @(negedge clk);

    // R2: consecutive write sweep
    for (int a = 0; a < NW; a++) begin
      issue(1, 0, a, pat(a));
      if (a == 0) a0 = acc_at;
    end
    check("R2 write sweep one per cycle", acc_at - a0, NW - 1);
    repeat (5) @(negedge clk);

    // R3: same-bank write spacing
    issue(1, 0, 0, pat(0)); a0 = acc_at;
    issue(1, 0, 4, pat(4)); a1 = acc_at;
    check("R3 same bank write spacing", a1 - a0, CYC);
    repeat (5) @(negedge clk);

    // R1: different superbank vs same bank
    issue(1, 0, 1, pat(1));   a0 = acc_at;
    issue(1, 0, 33, pat(33)); a1 = acc_at;
    check("R1 other superbank accepted next edge", a1 - a0, 1);
    issue(1, 0, 5, pat(5));   a2 = acc_at;
    check("R1 same bank held apart", a2 - a0, CYC);
    repeat (5) @(negedge clk);

    // R10: overwrite
    issue(1, 0, 9, 16'hBEEF);
    repeat (5) @(negedge clk);

    // R4: single read latency
    n0 = rsp_cnt;
    issue(0, 0, 9, '0); a0 = acc_at;
    while (rsp_cnt == n0) @(negedge clk);
    check("R4 read latency", last_rsp - a0, CYC - 1);
    drain();

    // R3: read holds bank until delivered
    issue(0, 0, 6, '0); a0 = acc_at;
    issue(0, 0, 6, '0); a1 = acc_at;
    check("R3 read bank busy until delivered", a1 - a0, CYC + 1);
    drain();

    // R5: read sweep in order
    for (int a = 0; a < NW; a++) issue(0, 0, a, '0);
    drain();

    // R6: line timing, unaligned address
    n0 = rsp_cnt;
    issue(0, 1, 8 + 3, '0); a0 = acc_at;
    while (rsp_cnt < n0 + NBANK) @(negedge clk);
    check("R6 line words consecutive", last_rsp - a0, CYC - 1 + NBANK - 1);
    drain();

    // R6: all lines with varied low bits
    for (int l = 0; l < NW / NBANK; l++) issue(0, 1, l * NBANK + (l % NBANK), '0);
    drain();

    // R7: line waits for pending bank in its superbank
    issue(0, 0, 2, '0); a0 = acc_at;
    issue(0, 1, 0, '0); a1 = acc_at;
    check("R7 line waits for busy bank", a1 - a0, CYC + 1);
    drain();

    // R8: independent superbanks and ordering
    issue(0, 1, 8, '0);  a0 = acc_at;
    issue(0, 0, 40, '0); a1 = acc_at;
    check("R8 other superbank during line", a1 - a0, 1);
    drain();
    check("R5 all responses delivered", er, ew);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule